// File: doc/BRIEF.md
# Grouped Interrupt Expander with Per-Group Acknowledge

This block lets a large population of peripheral interrupt sources share a small number of CPU interrupt lines. Ninety-six single-cycle source pulses are organised as twelve groups of eight. Each source owns a sticky flag and an enable bit. Each group owns one acknowledge latch. The block drives one request line per group toward the CPU's own per-line flag and enable stage. Two further CPU lines bypass the block entirely.

A group line pulses for one cycle when the group holds at least one flagged and enabled source and its acknowledge latch is clear. The same clock edge sets the latch, so a group can have only one interrupt outstanding. Software clears the latch by writing a one to it once the handler is done. When the CPU fetches a vector for a group, the block returns the index of the winning source in that group in the same cycle and clears that source's flag.

Priority is fixed. Lower-numbered groups win over higher-numbered ones, and lower positions win within a group. A synchronous register port gives read and write access to the flags and enables, and write-one-to-clear access to the acknowledge latches.

Top module: `irqx_expander`

## Requirements
- R1: After reset all flags, enables and acknowledge latches are zero, every group line is low, no vector is valid, and the read data is zero.
- R2: A pulse on source input s (group s/8, position s%8) sets that source's flag on the second clock edge after the pulse, because the input is registered once. This happens whether or not the source is enabled.
- R3: Group line g goes high for exactly one cycle, on the cycle after an edge at which group g had a flag and enable both set on the same position while its acknowledge latch was clear.
- R4: The edge that raises group line g also sets acknowledge latch g. While the latch is set, group g raises no further request, however many sources are pending.
- R5: A write to address 32 clears acknowledge latch g for every write-data bit g that is 1. Write-data bits that are 0 leave their latches unchanged.
- R6: With fetch_valid high and fetch_group = g (0..11) holding a pending enabled source, vec_valid is 1 in that same cycle and vec_index = 8*g + p, where p is the lowest pending enabled position. That flag clears at the next edge.
- R7: A fetch for a group with no pending enabled source, or for a group number from 12 to 15, gives vec_valid = 0 and vec_index = 0, and changes no flag.
- R8: If a source event reaches a flag in the same cycle as a fetch clear or a software flag write that would clear it, the flag ends up set.
- R9: A write to address g (0..11) loads group g's flags from write-data bits 7:0, with bit p meaning position p. A write to address 16+g loads that group's enables the same way. A read returns the addressed register on reg_rdata after the next edge, and a read of address 32 returns acknowledge latch g on bit g. Unmapped addresses read as zero, and reg_rdata holds its value between reads.
- R10: best_valid is high when at least one group is eligible, meaning it has a pending enabled source and a clear acknowledge latch. best_group is then the lowest-numbered eligible group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 96 | Single-cycle source pulses, bit 8*g+p is group g position p |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| fetch_valid | input | 1 | CPU vector fetch strobe |
| fetch_group | input | 4 | Group being fetched |
| vec_valid | output | 1 | A source was found for the fetch |
| vec_index | output | 7 | Flat index of the winning source |
| irq_group | output | 12 | Per-group request pulses toward the CPU |
| best_valid | output | 1 | Some group is eligible |
| best_group | output | 4 | Highest-priority eligible group |

## Verification
The bench first drives directed patterns, each aimed at one behaviour:
- A single source with its enable off, which separates flag latching from forwarding.
- Two pending positions in one group fetched repeatedly, which shows the in-group order and when the group runs dry.
- Simultaneous events in several groups, which shows the order across groups and that the group lines are independent.
- Writes of zero and then one to the acknowledge latch, which separate a clear from a no-op.
- An event timed onto a fetch clear, and another onto a software clear, which show that a colliding event survives.

A long run of random pulses, enables, acknowledge clears, fetches (including out-of-range groups) and reads then exercises all of these together. A behavioural model is compared with the design on every cycle.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int NG       = 12;
  localparam int GW       = 8;
  localparam int NSRC     = NG * GW;
  localparam int PW       = $clog2(GW);
  localparam int GSW      = $clog2(NG);
  localparam int VW       = $clog2(NSRC);
  localparam int AW       = 6;
  localparam int DW       = 16;
  localparam int EN_BASE  = 16;
  localparam int ACK_ADDR = 32;

  // lowest set position of a group vector (0 when empty)
  function automatic logic [PW-1:0] low_pos(input logic [GW-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = GW - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  // lowest set group number (0 when empty)
  function automatic logic [GSW-1:0] low_grp(input logic [NG-1:0] v);
    logic [GSW-1:0] r;
    r = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (v[i]) r = GSW'(i);
    end
    return r;
  endfunction

  // flat source index from group and position
  function automatic logic [VW-1:0] vec_of(input logic [GSW-1:0] g, input logic [PW-1:0] p);
    return VW'(VW'(g) * VW'(GW) + VW'(p));
  endfunction
endpackage

// File: rtl/irqx_group.sv
module irqx_group
  import irqx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] src_ev,
  input  logic          flag_wr,
  input  logic          en_wr,
  input  logic [GW-1:0] wr_bits,
  input  logic          ack_clr,
  input  logic          fetch_sel,
  output logic [GW-1:0] flag_o,
  output logic [GW-1:0] en_o,
  output logic          ack_o,
  output logic          irq_o,
  output logic          elig_o,
  output logic          hit_o,
  output logic [PW-1:0] hit_pos_o
);
  logic [GW-1:0] flag_q, en_q, pend, clr_mask, flag_base, flag_n;
  logic          ack_q, irq_q, any_pend;

  assign pend      = flag_q & en_q;
  assign any_pend  = |pend;
  assign elig_o    = any_pend & ~ack_q;
  assign hit_o     = fetch_sel & any_pend;
  assign hit_pos_o = low_pos(pend);
  assign clr_mask  = hit_o ? (GW'(1) << hit_pos_o) : '0;
  assign flag_base = flag_wr ? wr_bits : (flag_q & ~clr_mask);
  assign flag_n    = flag_base | src_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      if (en_wr) en_q <= wr_bits;
      ack_q  <= elig_o | (ack_q & ~ack_clr);
      irq_q  <= elig_o;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;
  assign irq_o  = irq_q;

  // R4
  irq_sets_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_q |-> ack_q);
  // R4
  ack_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(ack_q) |-> !irq_q);
  // R5
  ack_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n) (ack_q && ack_clr) |=> !ack_q);
  // R8
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ev) |=> ((flag_q & $past(src_ev)) == $past(src_ev)));
  // R6
  fetch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !flag_wr && !src_ev[hit_pos_o]) |=> !flag_q[$past(hit_pos_o)]);
endmodule

// File: rtl/irqx_prio.sv
module irqx_prio
  import irqx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NG-1:0]  elig,
  output logic           best_valid,
  output logic [GSW-1:0] best_group
);
  assign best_valid = |elig;
  assign best_group = low_grp(elig);

  // R10
  best_is_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> elig[best_group]);
  // R10
  best_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> ((elig & ((NG'(1) << best_group) - NG'(1))) == '0));
endmodule

// File: rtl/irqx_regport.sv
module irqx_regport
  import irqx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [AW-1:0]          reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  input  logic [NG-1:0][GW-1:0]  flags,
  input  logic [NG-1:0][GW-1:0]  ens,
  input  logic [NG-1:0]          acks,
  output logic [NG-1:0]          flag_wr,
  output logic [NG-1:0]          en_wr,
  output logic [NG-1:0]          ack_clr,
  output logic [DW-1:0]          reg_rdata
);
  logic          hit_ack;
  logic [DW-1:0] rd_mux;

  assign hit_ack = (reg_addr == AW'(ACK_ADDR));

  always_comb begin
    flag_wr = '0;
    en_wr   = '0;
    rd_mux  = '0;
    for (int g = 0; g < NG; g++) begin
      if (reg_addr == AW'(g)) begin
        flag_wr[g] = reg_wr;
        rd_mux     = DW'(flags[g]);
      end
      if (reg_addr == AW'(EN_BASE + g)) begin
        en_wr[g] = reg_wr;
        rd_mux   = DW'(ens[g]);
      end
    end
    if (hit_ack) rd_mux = DW'(acks);
  end

  assign ack_clr = (reg_wr && hit_ack) ? reg_wdata[NG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
  import irqx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             fetch_valid,
  input  logic [GSW-1:0]   fetch_group,
  output logic             vec_valid,
  output logic [VW-1:0]    vec_index,
  output logic [NG-1:0]    irq_group,
  output logic             best_valid,
  output logic [GSW-1:0]   best_group
);
  logic [NSRC-1:0]         src_q;
  logic [NG-1:0][GW-1:0]   flags, ens;
  logic [NG-1:0][PW-1:0]   hit_pos;
  logic [NG-1:0]           acks, elig, hit, fetch_sel, flag_wr, en_wr, ack_clr;
  logic [PW-1:0]           sel_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_req;
  end

  genvar g;
  generate
    for (g = 0; g < NG; g++) begin : grp
      assign fetch_sel[g] = fetch_valid && (fetch_group == GSW'(g));
      irqx_group u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_ev    (src_q[g*GW +: GW]),
        .flag_wr   (flag_wr[g]),
        .en_wr     (en_wr[g]),
        .wr_bits   (reg_wdata[GW-1:0]),
        .ack_clr   (ack_clr[g]),
        .fetch_sel (fetch_sel[g]),
        .flag_o    (flags[g]),
        .en_o      (ens[g]),
        .ack_o     (acks[g]),
        .irq_o     (irq_group[g]),
        .elig_o    (elig[g]),
        .hit_o     (hit[g]),
        .hit_pos_o (hit_pos[g])
      );
    end
  endgenerate

  always_comb begin
    sel_pos = '0;
    for (int i = 0; i < NG; i++) begin
      if (fetch_sel[i]) sel_pos = hit_pos[i];
    end
  end

  assign vec_valid = |hit;
  assign vec_index = vec_valid ? vec_of(fetch_group, sel_pos) : '0;

  irqx_prio u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig       (elig),
    .best_valid (best_valid),
    .best_group (best_group)
  );

  irqx_regport u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flags),
    .ens       (ens),
    .acks      (acks),
    .flag_wr   (flag_wr),
    .en_wr     (en_wr),
    .ack_clr   (ack_clr),
    .reg_rdata (reg_rdata)
  );

  // R6
  vec_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_index / VW'(GW)) == VW'(fetch_group));
  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!vec_valid && vec_index == '0));
  // R2
  src_to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ##1 ((flags & $past(src_req, 2)) == $past(src_req, 2)));
endmodule

// File: tb/irqx_expander_tb_top.sv
module irqx_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src_req = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, fetch_valid = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [3:0]  fetch_group = '0;
  logic [15:0] reg_rdata;
  logic        vec_valid, best_valid;
  logic [6:0]  vec_index;
  logic [11:0] irq_group;
  logic [3:0]  best_group;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqx_expander dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_valid(fetch_valid), .fetch_group(fetch_group), .vec_valid(vec_valid),
    .vec_index(vec_index), .irq_group(irq_group), .best_valid(best_valid),
    .best_group(best_group));

  // behavioural reference state
  logic [7:0]  m_flag [12];
  logic [7:0]  m_en   [12];
  logic [11:0] m_ack = '0, m_irq = '0;
  logic [95:0] m_srcq = '0;
  logic [15:0] m_rd = '0;

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int lowest8(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic clear_in();
    src_req = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    fetch_valid = 0; fetch_group = '0;
  endtask

  // one clock: compare outputs, then advance the model
  task automatic step(string tag);
    int ev, ei, bg;
    logic [7:0] nf [12];
    logic [7:0] ne [12];
    logic [11:0] na, ni;
    logic [15:0] nr;
    #5;
    ev = 0; ei = 0;
    if (fetch_valid && fetch_group < 12) begin
      int p;
      p = lowest8(m_flag[fetch_group] & m_en[fetch_group]);
      if (p >= 0) begin ev = 1; ei = fetch_group * 8 + p; end
    end
    bg = -1;
    for (int g = 11; g >= 0; g--)
      if (|(m_flag[g] & m_en[g]) && !m_ack[g]) bg = g;
    cmp(tag, "irq_group", irq_group, m_irq);
    cmp(tag, "reg_rdata", reg_rdata, m_rd);
    cmp(ev ? "R6" : "R7", "vec_valid", vec_valid, ev);
    cmp(ev ? "R6" : "R7", "vec_index", vec_index, ei);
    cmp("R10", "best_valid", best_valid, bg >= 0);
    if (bg >= 0) cmp("R10", "best_group", best_group, bg);
    @(posedge clk); #1;
    if (!rst_n) begin
      for (int g = 0; g < 12; g++) begin m_flag[g] = 0; m_en[g] = 0; end
      m_ack = 0; m_irq = 0; m_srcq = 0; m_rd = 0;
    end else begin
      na = m_ack; ni = 0; nr = m_rd;
      for (int g = 0; g < 12; g++) begin
        logic [7:0] pend, clr;
        pend = m_flag[g] & m_en[g];
        clr = 0;
        if (fetch_valid && fetch_group == g && pend != 0) clr[lowest8(pend)] = 1;
        nf[g] = (reg_wr && reg_addr == g) ? reg_wdata[7:0] : (m_flag[g] & ~clr);
        nf[g] = nf[g] | m_srcq[g*8 +: 8];
        ne[g] = (reg_wr && reg_addr == 16 + g) ? reg_wdata[7:0] : m_en[g];
        if (pend != 0 && !m_ack[g]) begin ni[g] = 1; na[g] = 1; end
        else if (reg_wr && reg_addr == 32 && reg_wdata[g]) na[g] = 0;
      end
      if (reg_rd) begin
        nr = 0;
        if (reg_addr < 12) nr = {8'h0, m_flag[reg_addr]};
        else if (reg_addr >= 16 && reg_addr < 28) nr = {8'h0, m_en[reg_addr - 16]};
        else if (reg_addr == 32) nr = {4'h0, m_ack};
      end
      for (int g = 0; g < 12; g++) begin m_flag[g] = nf[g]; m_en[g] = ne[g]; end
      m_ack = na; m_irq = ni; m_rd = nr; m_srcq = src_req;
    end
    @(negedge clk);
  endtask

  task automatic wr(string tag, int a, int d);
    clear_in(); reg_wr = 1; reg_addr = 6'(a); reg_wdata = 16'(d); step(tag); clear_in();
  endtask
  task automatic rd(string tag, int a);
    clear_in(); reg_rd = 1; reg_addr = 6'(a); step(tag); clear_in(); step(tag);
  endtask
  task automatic pulse(string tag, int s);
    clear_in(); src_req[s] = 1; step(tag); clear_in();
  endtask
  task automatic fetch(string tag, int g);
    clear_in(); fetch_valid = 1; fetch_group = 4'(g); step(tag); clear_in();
  endtask
  task automatic idle(string tag, int n);
    clear_in();
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    for (int g = 0; g < 12; g++) begin m_flag[g] = 0; m_en[g] = 0; end
    clear_in();
    @(negedge clk);
    idle("R1", 3);                // reset held
    rst_n = 1;
    idle("R1", 2);
    rd("R1", 0); rd("R1", 16); rd("R1", 32);
    // R2: flag latches with enable off, no request
    pulse("R2", 5); idle("R2", 3); rd("R2", 0);
    // R3/R4: enable position 3 and 5 of group 0
    pulse("R3", 3); idle("R3", 2);
    wr("R3", 16, 8'h28); idle("R3", 3);
    rd("R4", 32);
    pulse("R4", 1); wr("R4", 16, 8'h2A); idle("R4", 4);
    // R6/R7: fetch order in group 0
    fetch("R6", 0); fetch("R6", 0); fetch("R6", 0); fetch("R7", 0);
    fetch("R7", 13); fetch("R7", 15); rd("R6", 0);
    // R5: write zero then one to acknowledge
    wr("R5", 32, 0); rd("R5", 32);
    wr("R5", 32, 1); rd("R5", 32); idle("R5", 3);
    // R10: several groups at once
    wr("R9", 18, 8'hFF); wr("R9", 23, 8'h81); wr("R9", 27, 8'h40);
    clear_in(); src_req[2*8+6] = 1; src_req[7*8+0] = 1; src_req[11*8+6] = 1;
    step("R10"); clear_in(); idle("R10", 4);
    wr("R5", 32, 12'hFFF); idle("R10", 2);
    fetch("R6", 2); fetch("R6", 7); fetch("R6", 11); idle("R10", 2);
    // R8: event meets fetch clear
    wr("R8", 17, 8'h01);
    pulse("R8", 8); idle("R8", 1); pulse("R8", 8);
    fetch("R8", 1); rd("R8", 1);
    // R8: event meets software clear
    pulse("R8", 9); idle("R8", 1); pulse("R8", 9);
    wr("R8", 1, 0); rd("R8", 1);
    // R9: direct flag write and unmapped read
    wr("R9", 4, 8'hA5); rd("R9", 4); rd("R9", 40); rd("R9", 20);
    // mixed random traffic
    for (int c = 0; c < 3000; c++) begin
      clear_in();
      for (int s = 0; s < 96; s++) if ($urandom_range(0, 59) == 0) src_req[s] = 1;
      case ($urandom_range(0, 9))
        0: begin reg_wr = 1; reg_addr = 6'(16 + $urandom_range(0, 11)); reg_wdata = 16'($urandom_range(0, 255)); end
        1: begin reg_wr = 1; reg_addr = 6'd32; reg_wdata = 16'($urandom_range(0, 4095)); end
        2: begin reg_wr = 1; reg_addr = 6'($urandom_range(0, 11)); reg_wdata = 16'($urandom_range(0, 255)); end
        3, 4: begin reg_rd = 1; reg_addr = 6'($urandom_range(0, 40)); end
        default: ;
      endcase
      if ($urandom_range(0, 2) == 0) begin fetch_valid = 1; fetch_group = 4'($urandom_range(0, 15)); end
      step("R3");
    end
    idle("R4", 4);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule